// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles, one multiplier bit per cycle, using a single adder of operand width. A pulse on `start` while the unit is idle registers the multiplicand and places the multiplier in the lower half of a double-width product register with the upper half cleared. Each working cycle looks at the lowest product bit. If it is set, the multiplicand is added into the upper half. The whole register then moves one place to the right in the same cycle, and the adder's carry enters at the top bit so that no bit is lost.

After `WIDTH` working cycles the unit pulses `done` for one cycle. The product is then available as a high word and a low word, and it stays on the outputs until the next accepted start. A start pulse that arrives while the unit is working is ignored. The adder can be built either as a behavioural sum or as an explicit bit-level carry chain, chosen by a parameter.

Top module: `shift_add_mult`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy` and `done` are 0 and `hi` and `lo` are all zeros.
- R2: A `start` sampled high while `busy` is 0 makes `busy` read 1 on the next cycle.
- R3: After an accepted start, `busy` stays high for exactly `WIDTH` cycles. `done` is then high for exactly one cycle, with `busy` low.
- R4: In the `done` cycle, `{hi, lo}` equals the unsigned product of the operands sampled with the accepted start. `hi` holds the upper `WIDTH` bits and `lo` the lower `WIDTH` bits.
- R5: The carry out of each upper-half add is kept. All-ones operands give an upper word of all ones except a 0 in bit 0, and a lower word of 1.
- R6: Once `done` has been shown, `hi` and `lo` keep their value until the next accepted start.
- R7: A `start` sampled while `busy` is 1 has no effect. The result and the cycle of `done` are those of the operation already running.
- R8: A `start` sampled in the `done` cycle is accepted and begins a new operation.
- R9: A synchronous `rst` in the middle of an operation returns the unit to idle. `busy` and `done` are 0 on the next cycle and `done` does not rise afterwards without a new start.
- R10: Operands are taken only in the cycle a start is accepted. Changing `mcand` and `mplier` while busy does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted only while not busy) |
| mcand | input | WIDTH | Multiplicand operand |
| mplier | input | WIDTH | Multiplier operand |
| busy | output | 1 | High during the WIDTH working cycles |
| done | output | 1 | One-cycle completion pulse |
| hi | output | WIDTH | Upper half of the product |
| lo | output | WIDTH | Lower half of the product |

## Verification
The hardest cases to reach from the ports are the carry out of the upper-half add and a start pulse arriving in the middle of an operation. The carry only matters when the upper half is already large. All-ones operands and a full exhaustive sweep of a 6-bit instance drive it into every position. The bench raises `start` with different operands in the middle of a busy period, and again in the exact `done` cycle. This separates "ignored" from "accepted" by both the product and the completion cycle.

// File: rtl/smul_pkg.sv
package smul_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } smul_state_e;

   localparam int ADD_BEHAV  = 0;
   localparam int ADD_RIPPLE = 1;
endpackage

// File: rtl/smul_adder.sv
module smul_adder #(
   parameter int WIDTH = 32,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   import smul_pkg::*;

   generate
      if (STYLE == ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (a[i] & cy[i]) | (b[i] & cy[i]);
         end
         assign cout = cy[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, a} + {1'b0, b};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/smul_ctrl.sv
module smul_ctrl #(
   parameter int WIDTH = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   import smul_pkg::*;

   localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   smul_state_e      state_q, state_d;
   logic [CNT_W-1:0] iter_q, iter_d;

   always_comb begin
      state_d = state_q;
      iter_d  = iter_q;
      load    = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_DONE: begin
            if (start) begin
               load    = 1'b1;
               iter_d  = '0;
               state_d = ST_RUN;
            end else begin
               state_d = ST_IDLE;
            end
         end
         ST_RUN: begin
            if (iter_q == LAST) begin
               state_d = ST_DONE;
            end else begin
               iter_d = iter_q + 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         iter_q  <= '0;
      end else begin
         state_q <= state_d;
         iter_q  <= iter_d;
      end
   end

   assign step = (state_q == ST_RUN);
   assign busy = (state_q == ST_RUN);
   assign done = (state_q == ST_DONE);
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
   parameter int WIDTH = 32,
   parameter int STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic               step,
   input  logic [WIDTH-1:0]   mcand,
   input  logic [WIDTH-1:0]   mplier,
   output logic [2*WIDTH-1:0] prod
);
   localparam int PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [PW-1:0]    prod_q;
   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] upper_sum;
   logic             upper_cy;

   assign addend = prod_q[0] ? mcand_q : '0;

   smul_adder #(.WIDTH(WIDTH), .STYLE(STYLE)) u_add (
      .a    (prod_q[PW-1:WIDTH]),
      .b    (addend),
      .sum  (upper_sum),
      .cout (upper_cy)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mcand_q <= '0;
         prod_q  <= '0;
      end else if (load) begin
         mcand_q <= mcand;
         prod_q  <= {{WIDTH{1'b0}}, mplier};
      end else if (step) begin
         prod_q  <= {upper_cy, upper_sum, prod_q[WIDTH-1:1]};
      end
   end

   assign prod = prod_q;
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [WIDTH-1:0] mcand,
   input  logic [WIDTH-1:0] mplier,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] hi,
   output logic [WIDTH-1:0] lo
);
   localparam int PW = 2 * WIDTH;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shift_add_mult: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
         $error("shift_add_mult: ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   logic          load, step;
   logic [PW-1:0] prod;

   smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   smul_datapath #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_dp (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .step   (step),
      .mcand  (mcand),
      .mplier (mplier),
      .prod   (prod)
   );

   assign hi = prod[PW-1:WIDTH];
   assign lo = prod[WIDTH-1:0];
endmodule

// File: rtl/shift_add_mult_chk.sv
module shift_add_mult_chk #(
   parameter int WIDTH       = 32,
   parameter int ADDER_STYLE = 0
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [WIDTH-1:0] mcand,
   input logic [WIDTH-1:0] mplier,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] hi,
   input logic [WIDTH-1:0] lo
);
   localparam int CW = $clog2(WIDTH + 2);

   logic [2*WIDTH-1:0] ref_q;
   logic [CW-1:0]      busy_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_q    <= '0;
         busy_cnt <= '0;
      end else if (start && !busy) begin
         ref_q    <= {{WIDTH{1'b0}}, mcand} * {{WIDTH{1'b0}}, mplier};
         busy_cnt <= '0;
      end else if (busy) begin
         busy_cnt <= busy_cnt + 1'b1;
      end
   end

   AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy); // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done); // R3
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      !(done && busy)); // R3
   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
      done |-> (busy_cnt == CW'(WIDTH))); // R3
   AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (rst)
      done |-> ({hi, lo} == ref_q)); // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!busy && !start) |=> ($stable(hi) && $stable(lo))); // R6
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> (!busy && !done)); // R9
endmodule

bind shift_add_mult shift_add_mult_chk #(.WIDTH(WIDTH), .ADDER_STYLE(ADDER_STYLE)) u_chk (.*);

// File: tb/shift_add_mult_bench.sv
module shift_add_mult_bench;
   localparam int WB = 32;
   localparam int WS = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   logic          b_start = 1'b0;
   logic [WB-1:0] b_a = '0, b_b = '0;
   logic          b_busy, b_done;
   logic [WB-1:0] b_hi, b_lo;

   logic          s_start = 1'b0;
   logic [WS-1:0] s_a = '0, s_b = '0;
   logic          s_busy, s_done;
   logic [WS-1:0] s_hi, s_lo;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   shift_add_mult #(.WIDTH(WB), .ADDER_STYLE(0)) u_shift_add_mult (
      .clk(clk), .rst(rst), .start(b_start), .mcand(b_a), .mplier(b_b),
      .busy(b_busy), .done(b_done), .hi(b_hi), .lo(b_lo));

   shift_add_mult #(.WIDTH(WS), .ADDER_STYLE(1)) u_shift_add_mult_small (
      .clk(clk), .rst(rst), .start(s_start), .mcand(s_a), .mplier(s_b),
      .busy(s_busy), .done(s_done), .hi(s_hi), .lo(s_lo));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   // Counts negedges from the first busy cycle until done is seen.
   task automatic wait_big_done(output int n, input int spur_at,
                                input logic [WB-1:0] a2, input logic [WB-1:0] b2);
      n = 1;
      while (!b_done && n < 80) begin
         if (n == spur_at) begin
            b_start = 1'b1; b_a = a2; b_b = b2;
         end
         @(negedge clk);
         b_start = 1'b0;
         n++;
      end
   endtask

   task automatic op_big(input logic [WB-1:0] a, input logic [WB-1:0] b,
                         input int spur_at, input string req);
      logic [63:0] exp;
      logic [63:0] held;
      int n;
      exp = {32'b0, a} * {32'b0, b};
      @(negedge clk);
      b_start = 1'b1; b_a = a; b_b = b;
      @(negedge clk);
      b_start = 1'b0; b_a = ~a; b_b = a ^ b;   // R10: operands change while busy
      chk(b_busy == 1'b1, "R2", {63'b0, b_busy}, 64'd1);
      wait_big_done(n, spur_at, b ^ 32'h5A5A_0F0F, a + 32'd3);
      chk(n == WB + 1, "R3 latency", 64'(n), 64'(WB + 1));
      chk(!b_busy, "R3 busy low at done", {63'b0, b_busy}, 64'd0);
      chk({b_hi, b_lo} == exp, req, {b_hi, b_lo}, exp);
      held = {b_hi, b_lo};
      @(negedge clk);
      chk(!b_done, "R3 done one cycle", {63'b0, b_done}, 64'd0);
      @(negedge clk);
      @(negedge clk);
      chk({b_hi, b_lo} == held, "R6 hold", {b_hi, b_lo}, held);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 190000; c++) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
   end

   initial begin : main
      logic [63:0] e64;
      int n;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!b_busy && !b_done, "R1 flags", {62'b0, b_busy, b_done}, 64'd0);
      chk({b_hi, b_lo} == 64'd0, "R1 product", {b_hi, b_lo}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(!s_busy && !s_done && {s_hi, s_lo} == 12'd0, "R1 small",
          {50'b0, s_busy, s_done, s_hi, s_lo}, 64'd0);

      op_big(32'd0, 32'hFFFF_FFFF, -1, "R4 zero");
      op_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, "R5 all ones carry");
      op_big(32'h8000_0000, 32'h8000_0000, -1, "R5 top bits");
      op_big(32'd1, 32'h1234_5678, -1, "R4 one");
      op_big(32'hDEAD_BEEF, 32'h0000_0002, -1, "R4 shift");
      op_big(32'h1357_9BDF, 32'h2468_ACE0, 5, "R7 spurious start early");
      op_big(32'hFFFF_FFFF, 32'hFFFF_FFFE, 30, "R7 spurious start late");
      for (int i = 0; i < 120; i++) begin
         op_big($urandom(), $urandom(), -1, "R4 random");
      end

      // R8: start in the done cycle
      @(negedge clk);
      b_start = 1'b1; b_a = 32'hCAFE_0001; b_b = 32'h0000_FFFF;
      @(negedge clk);
      b_start = 1'b0;
      wait_big_done(n, -1, '0, '0);
      b_start = 1'b1; b_a = 32'hFFFF_0000; b_b = 32'h7777_7777;
      @(negedge clk);
      b_start = 1'b0;
      chk(b_busy == 1'b1, "R8 busy after done-cycle start", {63'b0, b_busy}, 64'd1);
      wait_big_done(n, -1, '0, '0);
      e64 = 64'hFFFF_0000 * 64'h7777_7777;
      chk(n == WB + 1, "R8 latency", 64'(n), 64'(WB + 1));
      chk({b_hi, b_lo} == e64, "R8 product", {b_hi, b_lo}, e64);

      // R9: reset in mid-operation
      @(negedge clk);
      b_start = 1'b1; b_a = 32'h0F0F_0F0F; b_b = 32'h3333_3333;
      @(negedge clk);
      b_start = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(!b_busy && !b_done, "R9 idle after reset", {62'b0, b_busy, b_done}, 64'd0);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (b_done || b_busy)
            chk(1'b0, "R9 no completion after reset", {62'b0, b_busy, b_done}, 64'd0);
      end
      n_chk++;

      // Exhaustive sweep of the small ripple-adder instance (R4, R5, R3)
      for (int a = 0; a < (1 << WS); a++) begin
         for (int b = 0; b < (1 << WS); b++) begin
            logic [11:0] es;
            es = 12'(a * b);
            @(negedge clk);
            s_start = 1'b1; s_a = 6'(a); s_b = 6'(b);
            @(negedge clk);
            s_start = 1'b0; s_a = 6'(b); s_b = 6'(a + 1);
            n = 1;
            while (!s_done && n < 20) begin
               @(negedge clk);
               n++;
            end
            if (n != WS + 1) chk(1'b0, "R3 small latency", 64'(n), 64'(WS + 1));
            chk({s_hi, s_lo} == es, "R4 small sweep", {52'b0, s_hi, s_lo}, {52'b0, es});
         end
      end
      summary();
   end
endmodule